// File: doc/BRIEF.md
# External Trigger Condition Detector

This block watches a small set of asynchronous trigger pins and raises one trigger flag per pin whenever a programmed condition on that pin is met. Each pin can be armed for any mix of five conditions: a rising transition, a falling transition, a transition in either direction, a sustained high level and a sustained low level. The flag for a pin is the OR of every condition that is armed for it.

Each raw pin first passes through a two-stage synchroniser. A transition is found by comparing the synchronised value with its value one cycle earlier. The per-pin flag is registered. The arming bits for all pins sit in one configuration word, with the bits of all pins for the same condition placed next to each other. The block is used ahead of the logic that merges external triggers with analog channel triggers.

Top module: `ext_trig_detect`

## Requirements
- R1: While `rst_n` is low every `pin_trig` bit is 0. After reset is released with the pins held low, no transition trigger is reported.
- R2: With P pins, the arming bit for condition c of pin p is `cond_cfg[c*P + p]`. The condition codes are low level = 0, high level = 1, either edge = 2, rising edge = 3 and falling edge = 4. For the default of two pins the bits are pin 0 low/high/either/rise/fall at 0/2/4/6/8 and pin 1 at 1/3/5/7/9.
- R3: When the rising condition is armed, a 0-to-1 change of the synchronised pin gives a `pin_trig` pulse exactly one cycle wide.
- R4: When the falling condition is armed, a 1-to-0 change of the synchronised pin gives a `pin_trig` pulse exactly one cycle wide.
- R5: When the either-edge condition is armed, a change in either direction gives a one-cycle pulse.
- R6: When the high-level condition is armed, `pin_trig` is 1 on every cycle on which the synchronised pin is 1.
- R7: When the low-level condition is armed, `pin_trig` is 1 on every cycle on which the synchronised pin is 0.
- R8: `pin_trig[p]` is the OR of all armed conditions of pin p. With no condition armed it stays 0.
- R9: A pin change that is set up before clock edge k shows on `pin_trig` after edge k+2 and not before. A change of `cond_cfg` takes effect on the flag after the next clock edge.
- R10: The conditions and level of one pin have no effect on the flag of any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_cfg | input | 5*NUM_PINS | Arming bits, condition c of pin p at bit c*NUM_PINS+p |
| pin_raw | input | NUM_PINS | Asynchronous external trigger pins |
| pin_trig | output | NUM_PINS | Registered per-pin trigger flag |

## Verification
The bench goes through all 1024 arming words and, for each word, all sixteen pairs of old and new pin levels. It compares the flag before, at and after the expected arrival cycle. A swapped bit position shows up as a pin responding to the wrong condition or to the other pin's settings. A wrong edge direction or a missing history register gives pulses on the wrong transition, or flags that stay high instead of lasting one cycle. An extra or missing synchroniser stage moves the pulse off the cycle the bench samples. Reset with every condition armed checks that the flags are quiet during reset and that no phantom edge appears afterwards.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

    typedef enum logic [2:0] {
        COND_LOW  = 3'd0,
        COND_HIGH = 3'd1,
        COND_ANY  = 3'd2,
        COND_RISE = 3'd3,
        COND_FALL = 3'd4
    } trig_cond_e;

    localparam int NUM_COND = 5;

    typedef struct packed {
        logic prev;
        logic trig;
    } cond_state_t;

    function automatic int cfg_index(input int cond, input int pin, input int pins);
        return cond * pins + pin;
    endfunction

endpackage

// File: rtl/ext_trig_sync.sv
module ext_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
    import ext_trig_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_in,
    input  logic [NUM_COND-1:0] arm,
    output logic                trig
);
    cond_state_t         st_d, st_q;
    logic [NUM_COND-1:0] hits;

    always_comb begin
        hits            = '0;
        hits[COND_LOW]  = ~sync_in;
        hits[COND_HIGH] = sync_in;
        hits[COND_ANY]  = sync_in ^ st_q.prev;
        hits[COND_RISE] = sync_in & ~st_q.prev;
        hits[COND_FALL] = ~sync_in & st_q.prev;
        st_d.prev       = sync_in;
        st_d.trig       = |(hits & arm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig = st_q.trig;
endmodule

// File: rtl/ext_trig_detect.sv
module ext_trig_detect
    import ext_trig_pkg::*;
#(
    parameter  int NUM_PINS    = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int CFG_W       = NUM_COND * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cond_cfg,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_trig
);
    logic [NUM_PINS-1:0] pin_sync;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [NUM_COND-1:0] arm;

        for (genvar c = 0; c < NUM_COND; c++) begin : g_arm
            assign arm[c] = cond_cfg[cfg_index(c, p, NUM_PINS)];
        end

        ext_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_raw[p]),
            .dout (pin_sync[p])
        );

        ext_trig_cond cond_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_in(pin_sync[p]),
            .arm    (arm),
            .trig   (pin_trig[p])
        );
    end
endmodule

// File: rtl/ext_trig_detect_chk.sv
module ext_trig_detect_chk
    import ext_trig_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_COND*NUM_PINS-1:0] cond_cfg,
    input logic [NUM_PINS-1:0]          pin_sync,
    input logic [NUM_PINS-1:0]          pin_trig
);
    always_comb begin
        if (!rst_n) AST_RESET_QUIET: assert (pin_trig == '0); // R1
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        localparam int B_LOW  = 0 * NUM_PINS + p;
        localparam int B_HIGH = 1 * NUM_PINS + p;
        localparam int B_ANY  = 2 * NUM_PINS + p;
        localparam int B_RISE = 3 * NUM_PINS + p;
        localparam int B_FALL = 4 * NUM_PINS + p;

        AST_RISE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
            cond_cfg[B_RISE] && pin_sync[p] && !$past(pin_sync[p]) |=> pin_trig[p]); // R3
        AST_FALL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
            cond_cfg[B_FALL] && !pin_sync[p] && $past(pin_sync[p]) |=> pin_trig[p]); // R4
        AST_ANY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
            cond_cfg[B_ANY] && (pin_sync[p] != $past(pin_sync[p])) |=> pin_trig[p]); // R5
        AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            cond_cfg[B_HIGH] && pin_sync[p] |=> pin_trig[p]); // R6
        AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            cond_cfg[B_LOW] && !pin_sync[p] |=> pin_trig[p]); // R7
        AST_NO_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !cond_cfg[B_LOW] && !cond_cfg[B_HIGH] && !cond_cfg[B_ANY]
            && !cond_cfg[B_RISE] && !cond_cfg[B_FALL] |=> !pin_trig[p]); // R8
        AST_STEADY_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_sync[p] == $past(pin_sync[p]))
            && !(cond_cfg[B_HIGH] && pin_sync[p])
            && !(cond_cfg[B_LOW] && !pin_sync[p]) |=> !pin_trig[p]); // R8
    end
endmodule

bind ext_trig_detect ext_trig_detect_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond_cfg(cond_cfg),
    .pin_sync(pin_sync),
    .pin_trig(pin_trig)
);

// File: tb/ext_trig_detect_tb_top.sv
`timescale 1ns/1ps
module ext_trig_detect_tb_top;
    localparam int NP = 2;
    localparam int CW = 5 * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cond_cfg = '0;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_trig;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ext_trig_detect #(.NUM_PINS(NP)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_cfg(cond_cfg),
        .pin_raw (pin_raw),
        .pin_trig(pin_trig)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic [NP-1:0] got, input logic [NP-1:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cfg=%h pins=%b got=%b exp=%b", tag, cond_cfg, pin_raw, got, exp);
        end
    endtask

    // Condition c of pin p sits at bit 2*c+p (R2): low 0, high 1, either 2, rise 3, fall 4.
    function automatic logic [NP-1:0] model(input logic [CW-1:0] cfg, input logic [NP-1:0] old_v,
                                            input logic [NP-1:0] new_v, input bit at_edge);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            r[p] = (cfg[0*NP+p] & ~new_v[p]) | (cfg[1*NP+p] & new_v[p]);
            if (at_edge && (old_v[p] != new_v[p]))
                r[p] |= cfg[2*NP+p] | (new_v[p] ? cfg[3*NP+p] : cfg[4*NP+p]);
        end
        return r;
    endfunction

    initial begin
        @(negedge clk);
        cond_cfg = '1;
        pin_raw  = '0;
        edges(2);
        check(pin_trig, '0, "R1 in reset");
        cond_cfg = {{(3*NP){1'b1}}, {(2*NP){1'b0}}};
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            edges(1);
            check(pin_trig, '0, "R1 no phantom edge");
        end

        for (int cfg = 0; cfg < (1 << CW); cfg++) begin
            for (int combo = 0; combo < 16; combo++) begin
                logic [NP-1:0] ov, nv;
                ov = combo[1:0];
                nv = combo[3:2];
                cond_cfg = cfg[CW-1:0];
                pin_raw  = ov;
                edges(4);
                check(pin_trig, model(cond_cfg, ov, ov, 1'b0), "R6/R7/R8/R10 steady old");
                pin_raw = nv;
                edges(2);
                check(pin_trig, model(cond_cfg, ov, ov, 1'b0), "R9 too early");
                edges(1);
                check(pin_trig, model(cond_cfg, ov, nv, 1'b1), "R3/R4/R5/R8/R9/R10 edge cycle");
                edges(1);
                check(pin_trig, model(cond_cfg, nv, nv, 1'b0), "R3/R4/R5 pulse width, R2");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule